// File: doc/BRIEF.md
# Streaming Stall Watchdog with Recovery

This block guards a streaming capture pipeline against a backpressure deadlock. It reads a free-running buffer-completion count and the capture machine's state index once per poll period, and counts consecutive polls on which the pipeline looks stuck. A poll looks stuck when the count has not moved since the previous poll, that previous value was non-zero (so streaming had begun), and the capture machine is waiting in a backpressure state. After enough such polls in a row, the block tears the pipeline down. It does this through a request/acknowledge step interface that stands in for the trigger, capture machine, DMA and endpoint controls.

When teardown is done, the block reads the PLL A lock bit from the clock status byte. If the clock is locked, it re-arms the transfer, starts the capture machine again and raises the run trigger. If the clock is not locked, it leaves the pipeline stopped until the host starts it again. A recovery cap stops endless recovery loops. The block also decides host start requests: a start is refused with a stall response unless the clock is enabled and PLL A is locked.

Top module: `stall_guard`

## Requirements
- R1: After reset, run_o, step_req_o, limit_o, evt_o and both counters are 0, and step_o is 0.
- R2: A host_start_i pulse gives start_ok_o one cycle later if clk_en_i is 1, clk_status_i bit 5 (PLL A loss of lock) is 0 and no recovery is running. Otherwise it gives start_stall_o. Bits 7 and 6 of the status byte do not affect the decision. An accepted start raises run_o.
- R3: A poll is a stall candidate only if cnt_i equals the stored sample and the stored sample is non-zero. A poll where the count has changed clears the stall count and stores cnt_i. A candidate with state_i not in {5,7,8,9} clears the stall count, so frozen data in a healthy state never triggers recovery.
- R4: Recovery starts on the poll that brings the run of consecutive candidates in states 5, 7, 8 or 9 to STALL_LIM (default 3).
- R5: Teardown drives step_o through codes 1 (trigger off), 2 (force-disable capture), 3 (DMA reset) and 4 (endpoint flush), in that order. step_req_o is high for the whole sequence. Each code is held until ack_i is sampled high. run_o is low from the first step.
- R6: If clk_status_i bit 5 is 0 when step 4 is acknowledged, codes 5 (re-arm transfer) and 6 (start capture) follow. At the end run_o is 1 and evt_restart_o is 1.
- R7: If bit 5 is 1 at that point, the sequence ends after step 4 with run_o 0 and evt_restart_o 0. Recovery then waits for a host start.
- R8: rec_cnt_o increments once when each recovery begins. evt_cnt_o increments and evt_o pulses for one cycle when each recovery ends. Both outcomes also clear the stall count and the stored sample.
- R9: If rec_cnt_o is already at least max_rec_i when the threshold is reached, no steps are issued, run_o is unchanged, limit_o is set and the stall count is cleared. An accepted host start clears limit_o.
- R10: While wdog_dis_i is high, the stall count, stored sample, recovery and event counters and the poll timer are held at zero, and no recovery starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdog_dis_i | input | 1 | Holds the watchdog counters at zero |
| cnt_i | input | CNT_W | Free-running buffer-completion count |
| state_i | input | 4 | Capture machine state index |
| clk_en_i | input | 1 | Sampling clock output enabled |
| clk_status_i | input | 8 | Clock status byte; bit 5 = PLL A loss of lock |
| host_start_i | input | 1 | Host start request pulse |
| max_rec_i | input | REC_W | Recovery cap |
| ack_i | input | 1 | Acknowledge for the current teardown/restart step |
| start_ok_o | output | 1 | Start accepted pulse |
| start_stall_o | output | 1 | Start refused (stall response) pulse |
| run_o | output | 1 | Run trigger to the capture pipeline |
| step_req_o | output | 1 | Step request valid |
| step_o | output | 3 | Current step code |
| evt_o | output | 1 | Recovery finished pulse |
| evt_restart_o | output | 1 | Last recovery restarted the pipeline |
| limit_o | output | 1 | Recovery cap hit |
| rec_cnt_o | output | REC_W | Recoveries started |
| evt_cnt_o | output | REC_W | Recoveries finished |

## Verification
The assertions assume three things about the inputs. ack_i is only meaningful while step_req_o is high. host_start_i is a single-cycle pulse. The step handshake does not stall forever. The bench meets these with a responder that raises ack_i for exactly one cycle after each new step code it sees, and with start pulses one clock wide. Inputs change only on the falling edge. The frozen-count scenarios hold cnt_i constant and non-zero, so the stored-sample rule is exercised both ways: immediately after a recovery clears it, and on long frozen runs.

// File: rtl/sg_pkg.sv
`timescale 1ns/1ps
package sg_pkg;
  localparam int STATE_W   = 4;
  localparam int LOL_A_BIT = 5;

  typedef enum logic [2:0] {
    STEP_NONE     = 3'd0,
    STEP_TRIG_OFF = 3'd1,
    STEP_SM_KILL  = 3'd2,
    STEP_DMA_RST  = 3'd3,
    STEP_EP_FLUSH = 3'd4,
    STEP_REARM    = 3'd5,
    STEP_SM_START = 3'd6
  } step_e;

  function automatic logic is_backpressure(input logic [STATE_W-1:0] s);
    return (s == 4'd5) || (s == 4'd7) || (s == 4'd8) || (s == 4'd9);
  endfunction
endpackage

// File: rtl/sg_poll_timer.sv
`timescale 1ns/1ps
module sg_poll_timer #(
  parameter int POLL_TICKS = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic tick_o
);
  localparam int TW = (POLL_TICKS > 1) ? $clog2(POLL_TICKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(POLL_TICKS - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (hold_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end

  p_hold_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (!tick_o && cnt_q == '0));
endmodule

// File: rtl/sg_stall_det.sv
`timescale 1ns/1ps
module sg_stall_det
  import sg_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int STALL_LIM = 3,
  parameter int REC_W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hold_i,
  input  logic               poll_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic               clr_i,
  input  logic               host_ok_i,
  input  logic [REC_W-1:0]   rec_cnt_i,
  input  logic [REC_W-1:0]   max_rec_i,
  output logic               go_o,
  output logic               limit_o
);
  localparam int SW = $clog2(STALL_LIM + 1);
  localparam logic [SW-1:0] LIM_M1 = SW'(STALL_LIM - 1);

  logic [CNT_W-1:0] prev_q;
  logic [SW-1:0]    stall_q;
  logic             moved, started, bp, hit;

  always_comb begin
    moved   = (cnt_i != prev_q);
    started = (prev_q != '0);
    bp      = is_backpressure(state_i);
    hit     = (stall_q == LIM_M1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      stall_q <= '0;
      go_o    <= 1'b0;
      limit_o <= 1'b0;
    end else if (hold_i) begin
      prev_q  <= '0;
      stall_q <= '0;
      go_o    <= 1'b0;
      limit_o <= 1'b0;
    end else begin
      go_o <= 1'b0;
      if (clr_i) begin
        prev_q  <= '0;
        stall_q <= '0;
      end else if (poll_i) begin
        if (moved) begin
          stall_q <= '0;
          prev_q  <= cnt_i;
        end else if (started) begin
          if (!bp) begin
            stall_q <= '0;  // transient
          end else if (hit) begin
            stall_q <= '0;
            if (rec_cnt_i >= max_rec_i) limit_o <= 1'b1;
            else                        go_o    <= 1'b1;
          end else begin
            stall_q <= stall_q + 1'b1;
          end
        end
      end
      if (host_ok_i) limit_o <= 1'b0;
    end
  end

  p_go_from_poll_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> ($past(poll_i) && $past(bp) && !$past(moved)));
  p_stall_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_q < SW'(STALL_LIM));
  p_limit_no_go_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(limit_o) |-> !go_o);
  p_hold_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (stall_q == '0 && prev_q == '0 && !go_o));
endmodule

// File: rtl/sg_start_gate.sv
`timescale 1ns/1ps
module sg_start_gate
  import sg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       clk_en_i,
  input  logic [7:0] status_i,
  input  logic       busy_i,
  output logic       ok_o,
  output logic       stall_o
);
  logic clock_good;
  logic unused_status;

  assign clock_good    = clk_en_i && !status_i[LOL_A_BIT];
  assign unused_status = ^{status_i[7:6], status_i[4:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_o    <= 1'b0;
      stall_o <= 1'b0;
    end else begin
      ok_o    <= start_i && clock_good && !busy_i;
      stall_o <= start_i && !(clock_good && !busy_i);
    end
  end

  p_ok_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && stall_o));
  p_ok_needs_clock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> ($past(clk_en_i) && !$past(status_i[LOL_A_BIT])));
endmodule

// File: rtl/sg_recover_seq.sv
`timescale 1ns/1ps
module sg_recover_seq
  import sg_pkg::*;
#(
  parameter int REC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             go_i,
  input  logic             start_i,
  input  logic             lock_i,
  input  logic             ack_i,
  output logic             run_o,
  output logic             busy_o,
  output step_e            step_o,
  output logic             evt_o,
  output logic             evt_restart_o,
  output logic [REC_W-1:0] rec_cnt_o,
  output logic [REC_W-1:0] evt_cnt_o
);
  localparam logic [REC_W-1:0] SAT = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o         <= 1'b0;
      busy_o        <= 1'b0;
      step_o        <= STEP_NONE;
      evt_o         <= 1'b0;
      evt_restart_o <= 1'b0;
      rec_cnt_o     <= '0;
      evt_cnt_o     <= '0;
    end else begin
      evt_o <= 1'b0;
      if (hold_i) begin
        busy_o    <= 1'b0;
        step_o    <= STEP_NONE;
        rec_cnt_o <= '0;
        evt_cnt_o <= '0;
        if (start_i) run_o <= 1'b1;
      end else if (!busy_o) begin
        if (go_i) begin
          busy_o <= 1'b1;
          run_o  <= 1'b0;
          step_o <= STEP_TRIG_OFF;
          if (rec_cnt_o != SAT) rec_cnt_o <= rec_cnt_o + 1'b1;
        end else if (start_i) begin
          run_o <= 1'b1;
        end
      end else if (ack_i) begin
        unique case (step_o)
          STEP_TRIG_OFF: step_o <= STEP_SM_KILL;
          STEP_SM_KILL:  step_o <= STEP_DMA_RST;
          STEP_DMA_RST:  step_o <= STEP_EP_FLUSH;
          STEP_EP_FLUSH: begin
            if (lock_i) step_o <= STEP_REARM;
            else begin
              busy_o        <= 1'b0;
              step_o        <= STEP_NONE;
              evt_o         <= 1'b1;
              evt_restart_o <= 1'b0;
              if (evt_cnt_o != SAT) evt_cnt_o <= evt_cnt_o + 1'b1;
            end
          end
          STEP_REARM:    step_o <= STEP_SM_START;
          STEP_SM_START: begin
            busy_o        <= 1'b0;
            step_o        <= STEP_NONE;
            run_o         <= 1'b1;
            evt_o         <= 1'b1;
            evt_restart_o <= 1'b1;
            if (evt_cnt_o != SAT) evt_cnt_o <= evt_cnt_o + 1'b1;
          end
          default: begin
            busy_o <= 1'b0;
            step_o <= STEP_NONE;
          end
        endcase
      end
    end
  end

  p_run_low_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !run_o);
  p_step_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ack_i && !hold_i) |=> $stable(step_o));
  p_restart_runs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && evt_restart_o) |-> run_o);
  p_wait_stopped_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && !evt_restart_o) |-> !run_o);
  p_rec_on_go_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(hold_i) && rec_cnt_o != $past(rec_cnt_o)) |-> $past(go_i));
  p_evt_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: rtl/stall_guard.sv
`timescale 1ns/1ps
module stall_guard
  import sg_pkg::*;
#(
  parameter int POLL_TICKS = 5_000_000,
  parameter int CNT_W      = 16,
  parameter int STALL_LIM  = 3,
  parameter int REC_W      = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wdog_dis_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic               clk_en_i,
  input  logic [7:0]         clk_status_i,
  input  logic               host_start_i,
  input  logic [REC_W-1:0]   max_rec_i,
  input  logic               ack_i,
  output logic               start_ok_o,
  output logic               start_stall_o,
  output logic               run_o,
  output logic               step_req_o,
  output logic [2:0]         step_o,
  output logic               evt_o,
  output logic               evt_restart_o,
  output logic               limit_o,
  output logic [REC_W-1:0]   rec_cnt_o,
  output logic [REC_W-1:0]   evt_cnt_o
);
  logic  tick, poll, go, busy, det_clr;
  step_e step;

  sg_poll_timer #(.POLL_TICKS(POLL_TICKS)) u_timer (
    .clk_i, .rst_ni, .hold_i(wdog_dis_i), .tick_o(tick)
  );

  assign poll    = tick && run_o && !busy;
  assign det_clr = evt_o || start_ok_o;

  sg_stall_det #(.CNT_W(CNT_W), .STALL_LIM(STALL_LIM), .REC_W(REC_W)) u_det (
    .clk_i, .rst_ni, .hold_i(wdog_dis_i), .poll_i(poll), .cnt_i, .state_i,
    .clr_i(det_clr), .host_ok_i(start_ok_o), .rec_cnt_i(rec_cnt_o),
    .max_rec_i, .go_o(go), .limit_o
  );

  sg_start_gate u_gate (
    .clk_i, .rst_ni, .start_i(host_start_i), .clk_en_i,
    .status_i(clk_status_i), .busy_i(busy),
    .ok_o(start_ok_o), .stall_o(start_stall_o)
  );

  sg_recover_seq #(.REC_W(REC_W)) u_seq (
    .clk_i, .rst_ni, .hold_i(wdog_dis_i), .go_i(go), .start_i(start_ok_o),
    .lock_i(!clk_status_i[LOL_A_BIT]), .ack_i, .run_o, .busy_o(busy),
    .step_o(step), .evt_o, .evt_restart_o, .rec_cnt_o, .evt_cnt_o
  );

  assign step_req_o = busy;
  assign step_o     = step;

  p_req_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_req_o |-> (step_o != 3'd0 && step_o != 3'd7));
endmodule

// File: tb/stall_guard_bench.sv
`timescale 1ns/1ps
module stall_guard_bench;
  localparam int POLL = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wdog_dis_i = 1'b0;
  logic [15:0] cnt_i = 16'd0;
  logic [3:0]  state_i = 4'd1;
  logic        clk_en_i = 1'b0;
  logic [7:0]  clk_status_i = 8'h00;
  logic        host_start_i = 1'b0;
  logic [7:0]  max_rec_i = 8'd2;
  logic        ack_i = 1'b0;
  logic        start_ok_o, start_stall_o, run_o, step_req_o, evt_o, evt_restart_o, limit_o;
  logic [2:0]  step_o;
  logic [7:0]  rec_cnt_o, evt_cnt_o;

  int errors = 0, checks = 0;
  int ok_seen = 0, stall_seen = 0, evt_seen = 0;
  logic last_restart = 1'b0;
  logic feed = 1'b0;
  int exp_q[$];

  always #10 clk_i = ~clk_i;

  stall_guard #(.POLL_TICKS(POLL)) u_stall_guard (.*);

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // feeder: advancing completion count while feed is set
  always @(negedge clk_i) if (feed) cnt_i = cnt_i + 16'd1;

  // monitor: step responder + scoreboard, pulse counters
  always @(negedge clk_i) begin
    if (start_ok_o) ok_seen++;
    if (start_stall_o) stall_seen++;
    if (evt_o) begin evt_seen++; last_restart = evt_restart_o; end
    if (step_req_o && !ack_i) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4/R9/R10: unexpected step %0d, expected none", step_o);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (int'(step_o) != e) begin
          errors++;
          $display("FAIL R5/R6: step got %0d expected %0d", step_o, e);
        end
      end
      ack_i = 1'b1;
    end else ack_i = 1'b0;
  end

  task automatic expect_recovery(input bit locked);
    for (int i = 1; i <= 4; i++) exp_q.push_back(i);
    if (locked) begin exp_q.push_back(5); exp_q.push_back(6); end
  endtask

  task automatic host_start();
    @(negedge clk_i) host_start_i = 1'b1;
    @(negedge clk_i) host_start_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic wait_polls(input int n);
    repeat (n * POLL) @(negedge clk_i);
  endtask

  task automatic wait_evt(input string req);
    int start = evt_seen;
    for (int i = 0; i < 600 && evt_seen == start; i++) @(negedge clk_i);
    check(req, evt_seen - start, 1);
    check(req, exp_q.size(), 0);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 run", run_o, 0);
    check("R1 req", step_req_o, 0);
    check("R1 step", step_o, 0);
    check("R1 rec", rec_cnt_o, 0);
    check("R1 evt", evt_cnt_o, 0);
    check("R1 limit", limit_o, 0);

    // R2 start gating
    host_start();
    check("R2 clk_en low rejected", stall_seen, 1);
    check("R2 run stays low", run_o, 0);
    clk_en_i = 1'b1; clk_status_i = 8'h20;
    host_start();
    check("R2 lol_a rejected", stall_seen, 2);
    clk_status_i = 8'hC0;
    host_start();
    check("R2 accepted with bits 7/6 set", ok_seen, 1);
    check("R2 run high", run_o, 1);
    clk_status_i = 8'h00;

    // R3 healthy flow, then frozen in a healthy state
    state_i = 4'd2; feed = 1'b1;
    wait_polls(8);
    check("R3 advancing no recovery", rec_cnt_o, 0);
    feed = 1'b0;
    wait_polls(8);
    check("R3 frozen healthy state ignored", rec_cnt_o, 0);
    check("R3 run kept", run_o, 1);

    // R4 R5 R6 locked recovery from state 5
    expect_recovery(1'b1);
    state_i = 4'd5;
    wait_evt("R4 R6 locked recovery");
    state_i = 4'd2;
    check("R6 restart flag", last_restart, 1);
    check("R6 run high", run_o, 1);
    check("R8 rec", rec_cnt_o, 1);
    check("R8 evt", evt_cnt_o, 1);

    // R7 unlocked recovery from state 9
    feed = 1'b1; wait_polls(2); feed = 1'b0;
    clk_status_i = 8'h20;
    expect_recovery(1'b0);
    state_i = 4'd9;
    wait_evt("R7 unlocked recovery");
    check("R7 restart flag", last_restart, 0);
    check("R7 run low", run_o, 0);
    check("R8 rec second", rec_cnt_o, 2);
    check("R8 evt second", evt_cnt_o, 2);
    wait_polls(6);
    check("R7 stays stopped", run_o, 0);

    // R9 cap reached
    clk_status_i = 8'h00; state_i = 4'd7;
    host_start();
    check("R9 restart accepted", ok_seen, 2);
    wait_polls(8);
    check("R9 limit set", limit_o, 1);
    check("R9 no new recovery", rec_cnt_o, 2);
    check("R9 run unchanged", run_o, 1);
    host_start();
    check("R9 host start clears limit", limit_o, 0);

    // R10 watchdog disable
    @(negedge clk_i) wdog_dis_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R10 rec held", rec_cnt_o, 0);
    check("R10 evt held", evt_cnt_o, 0);
    state_i = 4'd8;
    wait_polls(8);
    check("R10 no recovery while disabled", rec_cnt_o, 0);
    check("R10 limit clear", limit_o, 0);
    expect_recovery(1'b1);
    @(negedge clk_i) wdog_dis_i = 1'b0;
    wait_evt("R10 R4 recovery after enable");
    check("R8 rec after enable", rec_cnt_o, 1);
    check("R6 run after enable", run_o, 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (30000) @(posedge clk_i);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule